// File: doc/BRIEF.md
# Capture-Compare Timer with PWM and One-Shot Output

This block is a 16-bit up-counter with a selectable count source, two input-capture channels and one waveform output. The counter advances on a tick that comes either from a free-running prescaler (the system clock divided by 2, 4 or 8) or from detected transitions on an external clock pin. The pin is synchronised through two flip-flops, and its active transition is selectable. Each capture channel watches its own pin for a selectable transition. On that transition it latches the counter and raises a sticky flag.

Two compare registers shape the output. In one-shot mode, the active transition on capture pin 1 restarts the counter and drives the output high. The output drops once the counter reaches compare 1, and further triggers are ignored until then. In PWM mode, the counter runs from 0 up to compare 2 and then reloads to 0, raising capture flag 1 at each reload. The output is high while the counter is below compare 1.

Software reaches the block through a byte-wide strobed register port with combinational read data. A flag is cleared only by a two-step sequence: read the status register, then read or write the low byte of the matching capture register.

Top module: `cctimer`

## Requirements
- R1: The register map uses these addresses. 0 is the mode register, read/write. 1 is status. 2 and 3 are the capture 1 high and low bytes. 4 and 5 are the capture 2 high and low bytes. 6 and 7 are the compare 1 high and low bytes. 8 and 9 are the compare 2 high and low bytes. 10 and 11 are the counter high and low bytes. In the mode register, bit 5 is one-shot, bit 4 is PWM, bits 3:2 are the count source, bit 1 is the capture 2 edge and bit 0 is the external clock edge. A count source of 00 ticks once per 4 system clocks, 01 once per 2, 10 once per 8, and 11 selects the external pin.
- R2: With the external source selected, bit 0 of the mode register set to 1 makes a rising pin transition advance the counter by exactly one, and 0 makes a falling transition do so. The other transition and an idle pin leave the counter unchanged.
- R3: In a build without an external clock pin (HAS_EXT_CLK = 0), selecting source 11 stops the counter and holds its value regardless of the pin.
- R4: A capture 2 transition of the selected kind (mode bit 1: 1 rising, 0 falling) copies the counter into capture register 2 and sets status bit 6. The other transition does neither.
- R5: Status bit 0 is a read/write edge select for capture 1 (1 rising, 0 falling). A matching capture 1 transition copies the counter into capture register 1 and sets status bit 7. Status bits 7:6 are read-only.
- R6: A set capture flag stays set through a low-byte access that is not preceded by a status read that showed it set. It clears on a read or a write of its capture low byte that follows such a status read.
- R7: In one-shot mode, a capture 1 trigger resets the counter to 0 and drives the output high. The output goes low when the counter reaches compare 1. Triggers that arrive while the pulse is high do not restart the counter.
- R8: Writing the mode register with PWM newly set resets the counter to 0. In PWM mode the output is high while the counter is below compare 1. A tick with the counter equal to compare 2 reloads it to 0 and sets status bit 7. PWM takes precedence over one-shot when both bits are set.
- R9: After reset, the mode register, status, capture registers, counter and output are all 0.
- R10: The counter changes only by an increment of one or by a reload to 0, at most once per system clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (drives the side effects of a read) |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for `addr` |
| ext_clk | input | 1 | External count clock pin |
| cap1_in | input | 1 | Capture input 1, which is also the one-shot trigger |
| cap2_in | input | 1 | Capture input 2 |
| pulse_out | output | 1 | One-shot or PWM waveform output |

## Verification
A pin change on the external clock or a capture input reaches the counter, the capture registers, the flags and the output on the third rising edge after it is driven. The bench therefore holds every pin level for five cycles and samples on falling edges. A register write takes effect at the next rising edge, and read data is sampled one time unit after the address is set, before the edge that applies the read's side effects. Divider checks measure a window of exactly 64 edges between two mode writes, so the expected count is 64 divided by the ratio whatever the prescaler phase. Every other counter reading is taken with the external source selected and the pin idle, so the value is frozen while it is read.

// File: rtl/cctimer_pkg.sv
package cctimer_pkg;

    localparam int CNT_W = 16;
    localparam int PRE_W = 3;

    typedef enum logic [1:0] {
        CKS_DIV4 = 2'b00,
        CKS_DIV2 = 2'b01,
        CKS_DIV8 = 2'b10,
        CKS_EXT  = 2'b11
    } clk_src_e;

    typedef struct packed {
        logic     one_shot;
        logic     pwm_en;
        clk_src_e clk_src;
        logic     cap2_rise;
        logic     ext_rise;
    } mode_t;

    localparam logic [3:0] RA_MODE  = 4'd0;
    localparam logic [3:0] RA_STAT  = 4'd1;
    localparam logic [3:0] RA_CAP1H = 4'd2;
    localparam logic [3:0] RA_CAP1L = 4'd3;
    localparam logic [3:0] RA_CAP2H = 4'd4;
    localparam logic [3:0] RA_CAP2L = 4'd5;
    localparam logic [3:0] RA_CMP1H = 4'd6;
    localparam logic [3:0] RA_CMP1L = 4'd7;
    localparam logic [3:0] RA_CMP2H = 4'd8;
    localparam logic [3:0] RA_CMP2L = 4'd9;
    localparam logic [3:0] RA_CNTH  = 4'd10;
    localparam logic [3:0] RA_CNTL  = 4'd11;

    function automatic logic edge_match(input logic prev, input logic cur, input logic rise);
        return rise ? (!prev && cur) : (prev && !cur);
    endfunction

endpackage

// File: rtl/cctimer_edgedet.sv
module cctimer_edgedet
    import cctimer_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic rise_sel,
    output logic hit
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign hit = edge_match(prev_q, sync_q[SYNC_STAGES-1], rise_sel);
endmodule

// File: rtl/cctimer_tickgen.sv
module cctimer_tickgen
    import cctimer_pkg::*;
#(
    parameter bit HAS_EXT = 1'b1
) (
    input  logic     clk,
    input  logic     rst,
    input  clk_src_e src,
    input  logic     ext_hit,
    output logic     tick
);
    logic [PRE_W-1:0] pre_q;
    logic             ext_tick;

    always_ff @(posedge clk) begin
        if (rst) pre_q <= '0;
        else     pre_q <= pre_q + 1'b1;
    end

    if (HAS_EXT) begin : g_ext
        assign ext_tick = ext_hit;
    end else begin : g_noext
        assign ext_tick = 1'b0;
    end

    always_comb begin
        case (src)
            CKS_DIV4: tick = &pre_q[1:0];
            CKS_DIV2: tick = pre_q[0];
            CKS_DIV8: tick = &pre_q;
            default:  tick = ext_tick;
        endcase
    end
endmodule

// File: rtl/cctimer_capch.sv
module cctimer_capch #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hit,
    input  logic         extra_set,
    input  logic [W-1:0] cnt,
    input  logic         stat_rd,
    input  logic         lo_acc,
    output logic [W-1:0] cap,
    output logic         flag,
    output logic         armed
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cap   <= '0;
            flag  <= 1'b0;
            armed <= 1'b0;
        end else begin
            if (hit) cap <= cnt;
            if (stat_rd) armed <= flag;
            if (lo_acc) begin
                armed <= 1'b0;
                if (armed) flag <= 1'b0;
            end
            if (hit || extra_set) flag <= 1'b1;
        end
    end
endmodule

// File: rtl/cctimer.sv
module cctimer
    import cctimer_pkg::*;
#(
    parameter bit HAS_EXT_CLK  = 1'b1,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [3:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       ext_clk,
    input  logic       cap1_in,
    input  logic       cap2_in,
    output logic       pulse_out
);
    localparam int W = CNT_W;

    mode_t              mode_q;
    logic               cap1_rise_q;
    logic [W-1:0]       cmp1_q, cmp2_q, cnt_q, cnt_nxt;
    logic               busy_q, out_q;
    logic               ext_hit, tick;
    logic [1:0]         cap_pin, cap_rise, cap_hit, cap_extra, cap_lo, cap_flag, cap_armed;
    logic [1:0][W-1:0]  cap_val;
    logic               pwm_on, opm_on, mode_wr, pwm_start, trig, wrap, stat_rd;

    cctimer_edgedet #(.SYNC_STAGES(SYNC_STAGES)) u_extdet (
        .clk(clk), .rst(rst), .pin(ext_clk), .rise_sel(mode_q.ext_rise), .hit(ext_hit)
    );

    cctimer_tickgen #(.HAS_EXT(HAS_EXT_CLK)) u_tick (
        .clk(clk), .rst(rst), .src(mode_q.clk_src), .ext_hit(ext_hit), .tick(tick)
    );

    assign cap_pin   = {cap2_in, cap1_in};
    assign cap_rise  = {mode_q.cap2_rise, cap1_rise_q};
    assign cap_extra = {1'b0, wrap};
    assign cap_lo[0] = (wr_en || rd_en) && (addr == RA_CAP1L);
    assign cap_lo[1] = (wr_en || rd_en) && (addr == RA_CAP2L);
    assign stat_rd   = rd_en && (addr == RA_STAT);

    for (genvar i = 0; i < 2; i++) begin : g_cap
        cctimer_edgedet #(.SYNC_STAGES(SYNC_STAGES)) u_det (
            .clk(clk), .rst(rst), .pin(cap_pin[i]), .rise_sel(cap_rise[i]), .hit(cap_hit[i])
        );
        cctimer_capch #(.W(W)) u_ch (
            .clk(clk), .rst(rst), .hit(cap_hit[i]), .extra_set(cap_extra[i]),
            .cnt(cnt_q), .stat_rd(stat_rd), .lo_acc(cap_lo[i]),
            .cap(cap_val[i]), .flag(cap_flag[i]), .armed(cap_armed[i])
        );
    end

    assign pwm_on    = mode_q.pwm_en;
    assign opm_on    = mode_q.one_shot && !mode_q.pwm_en;
    assign mode_wr   = wr_en && (addr == RA_MODE);
    assign pwm_start = mode_wr && wdata[4] && !mode_q.pwm_en;
    assign trig      = opm_on && cap_hit[0] && !busy_q;
    assign wrap      = pwm_on && tick && (cnt_q == cmp2_q);

    always_comb begin
        if (pwm_start || trig || wrap) cnt_nxt = '0;
        else if (tick)                 cnt_nxt = cnt_q + 1'b1;
        else                           cnt_nxt = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q      <= '0;
            cap1_rise_q <= 1'b0;
            cmp1_q      <= '0;
            cmp2_q      <= '0;
        end else if (wr_en) begin
            case (addr)
                RA_MODE:  mode_q        <= mode_t'(wdata[5:0]);
                RA_STAT:  cap1_rise_q   <= wdata[0];
                RA_CMP1H: cmp1_q[W-1:8] <= wdata;
                RA_CMP1L: cmp1_q[7:0]   <= wdata;
                RA_CMP2H: cmp2_q[W-1:8] <= wdata;
                RA_CMP2L: cmp2_q[7:0]   <= wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            out_q  <= 1'b0;
            busy_q <= 1'b0;
        end else begin
            cnt_q <= cnt_nxt;
            if (pwm_on) begin
                out_q  <= (cnt_nxt < cmp1_q);
                busy_q <= 1'b0;
            end else if (opm_on) begin
                if (trig) begin
                    out_q  <= (cmp1_q != '0);
                    busy_q <= (cmp1_q != '0);
                end else if (busy_q && (cnt_nxt == cmp1_q)) begin
                    out_q  <= 1'b0;
                    busy_q <= 1'b0;
                end
            end else begin
                out_q  <= 1'b0;
                busy_q <= 1'b0;
            end
        end
    end

    always_comb begin
        case (addr)
            RA_MODE:  rdata = {2'b00, mode_q};
            RA_STAT:  rdata = {cap_flag[0], cap_flag[1], 5'b0, cap1_rise_q};
            RA_CAP1H: rdata = cap_val[0][W-1:8];
            RA_CAP1L: rdata = cap_val[0][7:0];
            RA_CAP2H: rdata = cap_val[1][W-1:8];
            RA_CAP2L: rdata = cap_val[1][7:0];
            RA_CMP1H: rdata = cmp1_q[W-1:8];
            RA_CMP1L: rdata = cmp1_q[7:0];
            RA_CMP2H: rdata = cmp2_q[W-1:8];
            RA_CMP2L: rdata = cmp2_q[7:0];
            RA_CNTH:  rdata = cnt_q[W-1:8];
            RA_CNTL:  rdata = cnt_q[7:0];
            default:  rdata = 8'h00;
        endcase
    end

    assign pulse_out = out_q;
endmodule

// File: rtl/cctimer_chk.sv
module cctimer_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] cnt,
    input logic [W-1:0] cmp1,
    input logic [W-1:0] cmp2,
    input logic         pwm_on,
    input logic         opm_on,
    input logic         out1,
    input logic         busy,
    input logic [1:0]   flag,
    input logic [1:0]   armed,
    input logic [1:0]   lo_acc
);
    // R10: counter only steps by one or reloads to zero
    a_r10_step: assert property (@(posedge clk) disable iff (rst)
        (cnt != $past(cnt)) |-> ((cnt == $past(cnt) + 16'd1) || (cnt == '0)));

    // R8: in steady PWM the counter never passes compare 2
    a_r8_ceiling: assert property (@(posedge clk) disable iff (rst)
        (pwm_on && $past(pwm_on) && $stable(cmp2) && ($past(cnt) <= cmp2)) |-> (cnt <= cmp2));

    // R7: a one-shot pulse begins with the counter at zero
    a_r7_start: assert property (@(posedge clk) disable iff (rst)
        (opm_on && $past(opm_on) && $rose(out1)) |-> (cnt == '0));

    // R7: a one-shot pulse ends with the counter at compare 1
    a_r7_end: assert property (@(posedge clk) disable iff (rst)
        (opm_on && $past(opm_on) && $stable(cmp1) && $fell(busy)) |-> (cnt == cmp1));

    // R6: flags clear only through the armed low-byte access
    a_r6_clear1: assert property (@(posedge clk) disable iff (rst)
        $fell(flag[0]) |-> $past(armed[0] && lo_acc[0]));
    a_r6_clear2: assert property (@(posedge clk) disable iff (rst)
        $fell(flag[1]) |-> $past(armed[1] && lo_acc[1]));
endmodule

bind cctimer cctimer_chk #(.W(cctimer_pkg::CNT_W)) u_chk (
    .clk(clk), .rst(rst), .cnt(cnt_q), .cmp1(cmp1_q), .cmp2(cmp2_q),
    .pwm_on(pwm_on), .opm_on(opm_on), .out1(out_q), .busy(busy_q),
    .flag(cap_flag), .armed(cap_armed), .lo_acc(cap_lo)
);

// File: tb/tb_cctimer.sv
module tb_cctimer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0] addr = 4'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata, rdata_n;
    logic       ext_clk = 1'b0, cap1_in = 1'b0, cap2_in = 1'b0;
    logic       pulse_out, pulse_out_n;
    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    cctimer dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ext_clk(ext_clk), .cap1_in(cap1_in), .cap2_in(cap2_in),
        .pulse_out(pulse_out)
    );

    cctimer #(.HAS_EXT_CLK(1'b0)) dut_noext (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata_n), .ext_clk(ext_clk), .cap1_in(cap1_in), .cap2_in(cap2_in),
        .pulse_out(pulse_out_n)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input bit alt, output logic [7:0] v);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 v = alt ? rdata_n : rdata;
        @(posedge clk);
        #1 rd_en = 1'b0;
    endtask

    task automatic rd16(input logic [3:0] hi, input bit alt, output int v);
        logic [7:0] h, l;
        rd(hi, alt, h);
        rd(hi + 4'd1, alt, l);
        v = {16'd0, h, l};
    endtask

    task automatic stat(output logic [7:0] v);
        rd(4'd1, 1'b0, v);
    endtask

    task automatic ext_pulse();
        @(negedge clk); ext_clk = 1'b1;
        repeat (5) @(negedge clk);
        ext_clk = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic cap_set(input int ch, input logic v);
        @(negedge clk);
        if (ch == 1) cap1_in = v; else cap2_in = v;
        repeat (5) @(negedge clk);
    endtask

    task automatic out_is(input string tag, input int exp);
        @(negedge clk);
        chk(tag, int'(pulse_out), exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] b;
        int v0, v1, vm, n0, n1;

        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R9 reset state
        rd(4'd0, 1'b0, b); chk("R9 mode reset", b, 0);
        stat(b);           chk("R9 status reset", b, 0);
        rd(4'd3, 1'b0, b); chk("R9 capture1 reset", b, 0);
        out_is("R9 output reset", 0);

        // R1 mode readback and divider ratios
        wr(4'd0, 8'h0D);
        rd(4'd0, 1'b0, b); chk("R1 mode readback", b, 8'h0D);
        rd16(4'd10, 1'b0, v0);
        for (int sel = 0; sel < 3; sel++) begin
            int div;
            div = (sel == 0) ? 4 : (sel == 1) ? 2 : 8;
            wr(4'd0, 8'(sel << 2));
            repeat (63) @(posedge clk);
            wr(4'd0, 8'h0D);
            rd16(4'd10, 1'b0, v1);
            chk($sformatf("R1 divider select %0d", sel), (v1 - v0) & 16'hFFFF, 64 / div);
            v0 = v1;
        end

        // R2 idle external pin does not count
        repeat (40) @(posedge clk);
        rd16(4'd10, 1'b0, v1);
        chk("R2 idle pin holds", v1, v0);

        // R3 build without external pin holds
        rd16(4'd10, 1'b1, n0);
        repeat (3) ext_pulse();
        rd16(4'd10, 1'b1, n1);
        chk("R3 no-pin counter holds", n1, n0);
        rd16(4'd10, 1'b0, v1);
        chk("R2 three rising edges", (v1 - v0) & 16'hFFFF, 3);

        // R2 edge polarity sweep
        for (int e = 0; e < 2; e++) begin
            wr(4'd0, 8'(8'h0C | e));
            for (int n = 1; n <= 3; n++) begin
                rd16(4'd10, 1'b0, v0);
                for (int p = 0; p < n; p++) begin
                    @(negedge clk); ext_clk = 1'b1;
                    repeat (5) @(negedge clk);
                    if (p == 0) begin
                        rd16(4'd10, 1'b0, vm);
                        chk($sformatf("R2 after rise edge=%0d", e), (vm - v0) & 16'hFFFF, e);
                    end
                    ext_clk = 1'b0;
                    repeat (5) @(negedge clk);
                end
                rd16(4'd10, 1'b0, v1);
                chk($sformatf("R2 pulses=%0d edge=%0d", n, e), (v1 - v0) & 16'hFFFF, n);
            end
        end

        // R4 capture 2, falling active
        wr(4'd0, 8'h0D);
        rd16(4'd10, 1'b0, v0);
        cap_set(2, 1'b1);
        stat(b); chk("R4 rise ignored when falling selected", b[6], 0);
        cap_set(2, 1'b0);
        rd16(4'd4, 1'b0, v1); chk("R4 capture2 value", v1, v0);
        stat(b); chk("R6 flag2 survives unarmed low read", b[6], 1);
        wr(4'd5, 8'h00);
        stat(b); chk("R6 flag2 cleared by write", b[6], 0);

        // R4 capture 2, rising active
        wr(4'd0, 8'h0F);
        ext_pulse();
        cap_set(2, 1'b1);
        rd16(4'd4, 1'b0, v1); chk("R4 capture2 rising value", v1, (v0 + 1) & 16'hFFFF);
        stat(b); chk("R4 flag2 set", b[6], 1);
        rd(4'd5, 1'b0, b);
        stat(b); chk("R6 flag2 cleared by read", b[6], 0);
        cap_set(2, 1'b0);
        stat(b); chk("R4 fall ignored when rising selected", b[6], 0);
        rd16(4'd4, 1'b0, v1); chk("R4 capture2 unchanged", v1, (v0 + 1) & 16'hFFFF);

        // R5 capture 1 edge select in status bit 0
        wr(4'd1, 8'h00);
        cap_set(1, 1'b1);
        stat(b); chk("R5 rise ignored flag1", b[7], 0);
        chk("R5 edge select readback 0", b[0], 0);
        cap_set(1, 1'b0);
        rd16(4'd2, 1'b0, v1); chk("R5 capture1 falling value", v1, (v0 + 1) & 16'hFFFF);
        stat(b); chk("R5 flag1 set", b[7], 1);
        wr(4'd3, 8'h00);
        wr(4'd1, 8'hC1);
        stat(b); chk("R5 flags read-only, flag1 cleared", b, 8'h01);
        ext_pulse();
        cap_set(1, 1'b1);
        rd16(4'd2, 1'b0, v1); chk("R5 capture1 rising value", v1, (v0 + 2) & 16'hFFFF);
        stat(b); chk("R5 flag1 set rising", b[7], 1);
        rd(4'd3, 1'b0, b);
        cap_set(1, 1'b0);

        // R7 one-shot, compare 1 = 4
        wr(4'd6, 8'h00); wr(4'd7, 8'h04);
        wr(4'd0, 8'h2D);
        cap_set(1, 1'b1);
        out_is("R7 output high on trigger", 1);
        rd16(4'd10, 1'b0, v1); chk("R7 counter restarted", v1, 0);
        ext_pulse(); ext_pulse();
        cap_set(1, 1'b0); cap_set(1, 1'b1);
        rd16(4'd10, 1'b0, v1); chk("R7 retrigger ignored", v1, 2);
        out_is("R7 still high", 1);
        ext_pulse();
        out_is("R7 high at 3", 1);
        ext_pulse();
        out_is("R7 low at compare", 0);
        rd16(4'd10, 1'b0, v1); chk("R7 counter at compare", v1, 4);
        ext_pulse();
        out_is("R7 stays low", 0);
        cap_set(1, 1'b0); cap_set(1, 1'b1);
        out_is("R7 retrigger after end", 1);
        rd16(4'd10, 1'b0, v1); chk("R7 counter restarted again", v1, 0);
        repeat (4) ext_pulse();
        out_is("R7 second pulse ends", 0);

        // R8 PWM, compare 1 = 3, compare 2 = 5, both mode bits set
        stat(b); rd(4'd3, 1'b0, b);
        wr(4'd7, 8'h03); wr(4'd9, 8'h05);
        ext_pulse();
        wr(4'd0, 8'h3D);
        repeat (3) @(negedge clk);
        out_is("R8 output high at start", 1);
        rd16(4'd10, 1'b0, v1); chk("R8 enable resets counter", v1, 0);
        stat(b); chk("R8 flag1 clear before reload", b[7], 0);
        for (int k = 1; k <= 12; k++) begin
            int ec;
            ext_pulse();
            ec = k % 6;
            rd16(4'd10, 1'b0, v1);
            chk($sformatf("R8 counter step %0d", k), v1, ec);
            out_is($sformatf("R8 output step %0d", k), (ec < 3) ? 1 : 0);
            if (k == 5) begin stat(b); chk("R8 no flag before reload", b[7], 0); end
            if (k == 6) begin stat(b); chk("R8 flag at reload", b[7], 1); end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule